// File: doc/BRIEF.md
# FIFO Port Width Adapter

This block sits on both sides of a FIFO whose storage word is always 36 bits wide. It lets the write port and the read port run at 36, 18 or 9 bits. On the write side, a packer collects one, two or four narrow words into a single 36-bit entry. It hands the entry to the core only when the entry is complete. On the read side, an unpacker shows one 36-bit core entry as one, two or four narrow words. It releases the core entry only when its last narrow word has been read.

All four interfaces use valid/ready handshakes. The adapter adds no register stage in the data path. The final narrow beat and the core transfer happen in the same cycle.

The port sizes and the byte order come from configuration pins. These pins are captured on every clock edge while reset is low and are then held.

Top module: `fifo_width_adapter`

## Requirements
- R1: Size codes on `cfg_in_sel` and `cfg_out_sel` are 0 = 36 bits, 1 = 18 bits, 2 = 9 bits. The accepted combinations are: both sides at 36 bits, or one side at 36 bits and the other at 18 or 9 bits. An accepted combination is used exactly as given.
- R2: Any other combination, meaning both sides narrow or either code equal to 3, makes the block run with 36 bits on both sides.
- R3: The configuration pins are captured only while `rst_n` is low. Changes on them after reset have no effect on the data or the handshakes.
- R4: A narrow port of width W uses 36/W beats per entry. `core_wr_valid` is high only when `wr_valid` is high on the final beat of an entry. On that beat `core_wr_data` carries the complete entry in the same cycle.
- R5: With `cfg_big_endian` = 1, the first beat of an entry occupies the most significant W bits, and later beats follow toward the least significant end. This holds for both packing and unpacking.
- R6: With `cfg_big_endian` = 0, the first beat occupies bits [W-1:0], and later beats follow toward the most significant end. This holds for both packing and unpacking.
- R7: Narrow data sits in bits [W-1:0] of `wr_data` and `rd_data`. Input bits above W are ignored. Output bits above W read as zero. `rd_valid` follows `core_rd_valid`.
- R8: `core_rd_ready` is high only when `rd_ready` is high on the final beat of the current core entry.
- R9: On a non-final write beat, `wr_ready` is 1. On the final beat, `wr_ready` equals `core_wr_ready`.
- R10: Reset returns both beat positions to the first beat. Any partly packed entry or partly read entry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_in_sel | input | 2 | Write port size code |
| cfg_out_sel | input | 2 | Read port size code |
| cfg_big_endian | input | 1 | 1 = first beat most significant, 0 = first beat least significant |
| wr_valid | input | 1 | Write beat valid |
| wr_data | input | 36 | Write beat, narrow data in the low bits |
| wr_ready | output | 1 | Write beat accepted |
| core_wr_valid | output | 1 | Packed entry valid toward the core |
| core_wr_data | output | 36 | Packed entry |
| core_wr_ready | input | 1 | Core accepts the entry |
| core_rd_valid | input | 1 | Core entry available |
| core_rd_data | input | 36 | Core entry |
| core_rd_ready | output | 1 | Core entry consumed |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 36 | Read beat, narrow data in the low bits |
| rd_ready | input | 1 | Reader takes the beat |

## Verification
The bench sends random beats with random gaps and random core backpressure in every legal pairing and in both byte orders. A design that mixes up the lane order, or that releases an entry one beat early or late, would show up as shifted or swapped entries at the core side. The bench also fills the input bits above the narrow width with random values and keeps changing the configuration pins after reset. This catches a design that does not mask its input or that keeps sampling its configuration.

Two directed cases cover the remaining corners. In the first, the bench resets in the middle of an entry on both sides; a design that kept its beat position would misalign every word that follows. In the second, it uses illegal size combinations; a design that did not fall back to 36 bits would pack or split words when it should pass them through whole.

// File: rtl/fwa_pkg.sv
package fwa_pkg;
  localparam int BYTE_W = 9;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int CNT_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_FULL = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2
  } size_e;

  typedef struct packed {
    size_e in_sz;
    size_e out_sz;
    logic  big;
  } cfg_t;

  // number of beats that make one storage word
  function automatic int beats(size_e s);
    case (s)
      SZ_HALF: return LANES / 2;
      SZ_BYTE: return LANES;
      default: return 1;
    endcase
  endfunction

  function automatic int beat_bits(size_e s);
    return WORD_W / beats(s);
  endfunction

  function automatic logic [CNT_W-1:0] last_idx(size_e s);
    return CNT_W'(beats(s) - 1);
  endfunction

  // bit position of beat k inside the storage word
  function automatic int lane_lsb(size_e s, logic [CNT_W-1:0] k, logic big);
    int w;
    w = beat_bits(s);
    return big ? (WORD_W - w * (int'(k) + 1)) : (w * int'(k));
  endfunction

  function automatic logic [WORD_W-1:0] beat_mask(size_e s);
    return {WORD_W{1'b1}} >> (WORD_W - beat_bits(s));
  endfunction

  function automatic cfg_t decode(logic [1:0] i, logic [1:0] o, logic big);
    cfg_t c;
    c.big = big;
    if ((i == 2'd0 && o != 2'd3) || (o == 2'd0 && i != 2'd3)) begin
      c.in_sz  = size_e'(i);
      c.out_sz = size_e'(o);
    end else begin
      c.in_sz  = SZ_FULL;
      c.out_sz = SZ_FULL;
    end
    return c;
  endfunction
endpackage

// File: rtl/fwa_cfg_latch.sv
module fwa_cfg_latch
  import fwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] in_sel,
  input  logic [1:0] out_sel,
  input  logic       big,
  output cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= decode(in_sel, out_sel, big);
  end
endmodule

// File: rtl/fwa_packer.sv
module fwa_packer
  import fwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  size_e             sz,
  input  logic              big,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              beat_acc,
  output logic              entry_out
);
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] acc, merged, lane_msk;
  logic              is_last;
  int                lsb;

  always_comb begin
    is_last   = (idx == last_idx(sz));
    lsb       = lane_lsb(sz, idx, big);
    lane_msk  = beat_mask(sz) << lsb;
    merged    = (acc & ~lane_msk) | ((in_data & beat_mask(sz)) << lsb);
    out_data  = merged;
    out_valid = in_valid && is_last;
    in_ready  = is_last ? out_ready : 1'b1;
    beat_acc  = in_valid && in_ready;
    entry_out = out_valid && out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= '0;
    end else if (beat_acc) begin
      if (is_last) begin
        idx <= '0;
        acc <= '0;
      end else begin
        idx <= idx + 1'b1;
        acc <= merged;
      end
    end
  end
endmodule

// File: rtl/fwa_unpacker.sv
module fwa_unpacker
  import fwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  size_e             sz,
  input  logic              big,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              beat_take,
  output logic              entry_done
);
  logic [CNT_W-1:0] idx;
  logic             is_last;
  int               lsb;

  always_comb begin
    is_last    = (idx == last_idx(sz));
    lsb        = lane_lsb(sz, idx, big);
    out_data   = (in_data >> lsb) & beat_mask(sz);
    out_valid  = in_valid;
    in_ready   = out_ready && is_last;
    beat_take  = out_valid && out_ready;
    entry_done = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         idx <= '0;
    else if (beat_take) idx <= is_last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/fifo_width_adapter.sv
module fifo_width_adapter
  import fwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_in_sel,
  input  logic [1:0]        cfg_out_sel,
  input  logic              cfg_big_endian,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              core_wr_valid,
  output logic [WORD_W-1:0] core_wr_data,
  input  logic              core_wr_ready,
  input  logic              core_rd_valid,
  input  logic [WORD_W-1:0] core_rd_data,
  output logic              core_rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rd_ready
);
  cfg_t cfg;
  logic pk_beat, pk_emit, up_take, up_retire;

  fwa_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .in_sel(cfg_in_sel), .out_sel(cfg_out_sel),
    .big(cfg_big_endian), .cfg(cfg)
  );

  fwa_packer u_pack (
    .clk(clk), .rst_n(rst_n), .sz(cfg.in_sz), .big(cfg.big),
    .in_valid(wr_valid), .in_data(wr_data), .in_ready(wr_ready),
    .out_valid(core_wr_valid), .out_data(core_wr_data), .out_ready(core_wr_ready),
    .beat_acc(pk_beat), .entry_out(pk_emit)
  );

  fwa_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .sz(cfg.out_sz), .big(cfg.big),
    .in_valid(core_rd_valid), .in_data(core_rd_data), .in_ready(core_rd_ready),
    .out_valid(rd_valid), .out_data(rd_data), .out_ready(rd_ready),
    .beat_take(up_take), .entry_done(up_retire)
  );
endmodule

// File: rtl/fwa_checks.sv
module fwa_checks
  import fwa_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input cfg_t cfg,
  input logic pk_beat,
  input logic pk_emit,
  input logic up_take,
  input logic up_retire
);
  logic [CNT_W:0] wc, rc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wc <= '0;
      rc <= '0;
    end else begin
      if (pk_emit)      wc <= '0;
      else if (pk_beat) wc <= wc + 1'b1;
      if (up_retire)    rc <= '0;
      else if (up_take) rc <= rc + 1'b1;
    end
  end

  a_r1_pairing_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.in_sz == SZ_FULL || cfg.out_sz == SZ_FULL) &&
    cfg.in_sz != size_e'(2'd3) && cfg.out_sz != size_e'(2'd3));

  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg));

  a_r4_emit_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    pk_emit |-> (wc == {1'b0, last_idx(cfg.in_sz)}));

  a_r4_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wc <= {1'b0, last_idx(cfg.in_sz)});

  a_r9_emit_with_beat: assert property (@(posedge clk) disable iff (!rst_n)
    pk_emit |-> pk_beat);

  a_r8_retire_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    up_retire |-> (up_take && rc == {1'b0, last_idx(cfg.out_sz)}));
endmodule

bind fifo_width_adapter fwa_checks u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .pk_beat(pk_beat), .pk_emit(pk_emit),
  .up_take(up_take), .up_retire(up_retire)
);

// File: tb/tb_fifo_width_adapter.sv
module tb_fifo_width_adapter;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  cfg_in_sel = 0, cfg_out_sel = 0;
  logic        cfg_big_endian = 0;
  logic        wr_valid = 0, wr_ready, core_wr_valid, core_wr_ready = 0;
  logic [35:0] wr_data = 0, core_wr_data, core_rd_data = 0, rd_data;
  logic        core_rd_valid = 0, core_rd_ready, rd_valid, rd_ready = 0;

  int total = 0, bad = 0;
  int ein, eout, ebig;
  string wtag, rtag;
  logic [35:0] wq [0:63];
  logic [35:0] rq [0:15];

  fifo_width_adapter dut (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wid(int code);
    return code == 1 ? 18 : (code == 2 ? 9 : 36);
  endfunction

  task automatic do_reset(int i, int o, int b);
    rst_n = 0; cfg_in_sel = 2'(i); cfg_out_sel = 2'(o); cfg_big_endian = b[0];
    wr_valid = 0; core_wr_ready = 0; core_rd_valid = 0; rd_ready = 0;
    if ((i == 0 && o != 3) || (o == 0 && i != 3)) begin ein = i; eout = o; end
    else begin ein = 0; eout = 0; end
    ebig = b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10 idle core_wr_valid", 36'(core_wr_valid), 36'd0);
    chk("R10 idle core_rd_ready", 36'(core_rd_ready), 36'd0);
  endtask

  function automatic logic [35:0] exp_entry(int j);
    int w = wid(ein);
    int n = 36 / w;
    logic [35:0] e = '0;
    for (int k = 0; k < n; k++) begin
      if (ebig != 0) e = (e << w) | wq[j*n+k];
      else           e = e | (wq[j*n+k] << (w*k));
    end
    return e;
  endfunction

  function automatic logic [35:0] exp_beat(int j, int k);
    int w = wid(eout);
    logic [35:0] m = (36'd1 << w) - 1;
    if (w == 36) return rq[j];
    if (ebig != 0) return (rq[j] >> (36 - w*(k+1))) & m;
    return (rq[j] >> (w*k)) & m;
  endfunction

  task automatic run_write(int ne);
    int w = wid(ein);
    int n = 36 / w;
    int sent = 0, got = 0;
    logic [35:0] m = (w == 36) ? '1 : ((36'd1 << w) - 1);
    for (int i = 0; i < ne*n; i++) wq[i] = {$urandom, $urandom} & m;
    while (got < ne) begin
      @(negedge clk);
      cfg_in_sel = 2'($urandom); cfg_out_sel = 2'($urandom); cfg_big_endian = 1'($urandom);
      wr_valid = (sent < ne*n) && ($urandom % 4 != 0);
      wr_data = (sent < ne*n) ? (wq[sent] | ({$urandom, $urandom} & ~m)) : 36'h0;
      core_wr_ready = ($urandom % 3 != 0);
      #1;
      chk("R9 wr_ready", 36'(wr_ready),
          36'((sent % n == n-1) ? core_wr_ready : 1'b1));
      chk("R4 core_wr_valid", 36'(core_wr_valid),
          36'(wr_valid && (sent % n == n-1)));
      if (core_wr_valid && core_wr_ready) begin
        chk(wtag, core_wr_data, exp_entry(got));
        got++;
      end
      if (wr_valid && wr_ready) sent++;
    end
    @(negedge clk); wr_valid = 0; core_wr_ready = 0;
  endtask

  task automatic run_read(int ne);
    int n = 36 / wid(eout);
    int ent = 0, bt = 0;
    for (int i = 0; i < ne; i++) rq[i] = {$urandom, $urandom};
    while (ent < ne) begin
      @(negedge clk);
      cfg_in_sel = 2'($urandom); cfg_out_sel = 2'($urandom); cfg_big_endian = 1'($urandom);
      core_rd_valid = ($urandom % 4 != 0);
      core_rd_data = core_rd_valid ? rq[ent] : {$urandom, $urandom};
      rd_ready = ($urandom % 3 != 0);
      #1;
      chk("R7 rd_valid", 36'(rd_valid), 36'(core_rd_valid));
      chk("R8 core_rd_ready", 36'(core_rd_ready), 36'(rd_ready && bt == n-1));
      if (rd_valid) chk(rtag, rd_data, exp_beat(ent, bt));
      if (rd_valid && rd_ready) begin
        bt++;
        if (bt == n) begin bt = 0; ent++; end
      end
    end
    @(negedge clk); core_rd_valid = 0; rd_ready = 0;
  endtask

  initial begin
    int pi [5] = '{0, 0, 0, 1, 2};
    int po [5] = '{0, 1, 2, 0, 0};
    void'($urandom(32'd2024));
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < 5; p++) begin
        wtag = b ? "R1 R5 pack" : "R1 R6 pack";
        rtag = b ? "R3 R5 R7 unpack" : "R3 R6 R7 unpack";
        do_reset(pi[p], po[p], b);
        run_write(8);
        run_read(8);
      end
    end
    // illegal combinations fall back to full width
    wtag = "R2 pack"; rtag = "R2 unpack";
    do_reset(2, 1, 1); run_write(6); run_read(6);
    do_reset(3, 0, 0); run_write(6); run_read(6);
    do_reset(1, 1, 0); run_write(6); run_read(6);
    // partial entry discarded by reset, write side
    wtag = "R10 pack after partial";
    do_reset(2, 0, 1);
    @(negedge clk); wr_valid = 1; wr_data = 36'h1AA; core_wr_ready = 1;
    @(negedge clk); wr_data = 36'h155;
    @(negedge clk); wr_valid = 0;
    do_reset(2, 0, 1); run_write(4);
    // partial entry discarded by reset, read side
    rtag = "R10 unpack after partial";
    do_reset(0, 2, 0);
    @(negedge clk); core_rd_valid = 1; core_rd_data = 36'hF0F0F0F0F; rd_ready = 1;
    @(negedge clk); core_rd_valid = 0; rd_ready = 0;
    do_reset(0, 2, 0); run_read(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule